// File: doc/BRIEF.md
# Dual-Channel PWM Chopper Controller

This block regulates the current in two motor windings by fixed-frequency set/reset chopping. A chop tick, shared by both channels, arms a per-channel enable latch. Each channel has a digital over-current trip input that stands in for its sense comparator. A trip clears that channel's latch, and the latch stays clear until the next chop tick. While a channel's latch is clear, its drive stage is chopped in one of two styles.

In inhibit style, the channel's active-low inhibit line is pulled low. Both ends of the winding then float onto their diodes, and the current decays fast. In phase style, the idle phase line of the pair is driven high next to the active one, so the current recirculates through the high side and decays slowly.

The chop tick comes from one of two sources. It can come from an internal down-counter with a programmable period, which also drives a one-cycle active-low sync pulse out to other controllers. Otherwise it is taken from the falling edge of an external sync input after synchronization. A low enable forces every drive output low.

Top module: `dual_chopper`

## Requirements
- R1: With `osc_internal` high, a chop tick occurs every `period` clock cycles (a period of 0 acts as 1). The first tick falls in the first cycle after reset is released. `sync_out_n` is low exactly in tick cycles, for one cycle each when `period` > 1.
- R2: A chop tick sets the enable latch of both channels at the next clock edge.
- R3: A high `trip[i]` clears latch i at the next edge, and the latch stays clear until a later tick. When a trip and a tick fall in the same cycle, the trip wins.
- R4: In inhibit style (`chop_on_phase` low, `enable` high), `phase_out` equals `phase_req`, and `inh_n[i]` is high exactly while latch i is set.
- R5: In phase style (`chop_on_phase` high, `enable` high), `inh_n` is 2'b11. While latch i is clear and its requested pair is not 00, both lines of the pair are driven 1. Otherwise the pair follows `phase_req`. Bit order is {A,B,C,D} = bits [3:0]. Channel 0 is A/B (bits 3:2) with `trip[0]` and `inh_n[0]`. Channel 1 is C/D (bits 1:0).
- R6: A low `enable` drives `phase_out` and `inh_n` to all zeros, whatever the other inputs and latch states.
- R7: With `osc_internal` low, `sync_out_n` stays high and the internal counter makes no ticks. A falling edge of `sync_in` that is first sampled at edge k produces a tick in the cycle after edge k+1, so the latches are set at edge k+2.
- R8: Reset clears both latches, loads the counter so that a tick is due at once, and sets the sync synchronizer to the idle-high state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Low forces all drive outputs low |
| chop_on_phase | input | 1 | 1: phase-style chopping, 0: inhibit-style chopping |
| osc_internal | input | 1 | 1: internal chop counter, 0: external sync input |
| period | input | PW | Internal chop period in clock cycles |
| sync_in | input | 1 | External chop clock; its falling edge is a tick |
| sync_out_n | output | 1 | Active-low one-cycle pulse per internal tick |
| trip | input | 2 | Per-channel over-current trip, active high |
| phase_req | input | 4 | Requested phase pattern {A,B,C,D} |
| phase_out | output | 4 | Phase drive outputs {A,B,C,D} |
| inh_n | output | 2 | Active-low inhibit per channel |

## Verification
The critical coincidence is a chop tick and a trip on the same channel in the same cycle. The latch must end up clear, so the trip has to win. The bench provokes this heavily: it runs with a period of 1, where every cycle is a tick, and with random trips under every period and both tick sources. It judges the result by whether the inhibit or phase outputs show a chopped channel in the following cycle. The enable override can also coincide with any chopping state, and it is judged by requiring all-zero outputs no matter what the latches hold.

// File: rtl/dual_chopper.sv
module dual_chopper #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          chop_on_phase,
  input  logic          osc_internal,
  input  logic [PW-1:0] period,
  input  logic          sync_in,
  output logic          sync_out_n,
  input  logic [1:0]    trip,
  input  logic [3:0]    phase_req,
  output logic [3:0]    phase_out,
  output logic [1:0]    inh_n
);

  logic [PW-1:0] cnt;
  logic [2:0]    sy;
  logic [1:0]    armed;

  wire tick_int = (cnt == '0);
  wire tick_ext = sy[2] & ~sy[1];
  wire tick     = osc_internal ? tick_int : tick_ext;

  assign sync_out_n = ~(osc_internal & tick_int);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sy    <= 3'b111;
      armed <= 2'b00;
    end else begin
      cnt <= tick_int ? ((period == '0) ? '0 : period - 1'b1) : cnt - 1'b1;
      sy  <= {sy[1:0], sync_in};
      for (int i = 0; i < 2; i++)
        armed[i] <= trip[i] ? 1'b0 : (tick ? 1'b1 : armed[i]);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam int LO = 2 * (1 - g);
    wire [1:0] req = phase_req[LO +: 2];
    assign phase_out[LO +: 2] = !enable ? 2'b00 :
                                (chop_on_phase && !armed[g] && |req) ? 2'b11 : req;
    assign inh_n[g] = enable & (chop_on_phase | armed[g]);

    assert_trip_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trip[g] |=> !armed[g]);
    assert_tick_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !trip[g]) |=> armed[g]);
    assert_hold_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed[g] && !tick) |=> !armed[g]);
  end

  assert_enable_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (phase_out == 4'b0000 && inh_n == 2'b00));
  assert_inhibit_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !chop_on_phase) |-> phase_out == phase_req);
  assert_phase_inh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && chop_on_phase) |-> inh_n == 2'b11);
  assert_ext_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_internal |-> sync_out_n);
  assert_sync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_out_n && period > 1) |=> sync_out_n);

endmodule

// File: tb/dual_chopper_tb.sv
module dual_chopper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;

  logic clk = 0, rst_n = 0, enable = 0, chop_on_phase = 0, osc_internal = 1, sync_in = 1;
  logic [PW-1:0] period = 1;
  logic [1:0] trip = 0;
  logic [3:0] phase_req = 0;
  logic sync_out_n;
  logic [3:0] phase_out;
  logic [1:0] inh_n;

  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic h [0:255];
  logic [1:0] m_latch;

  dual_chopper #(.PW(PW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic hv(input int j);
    return (j < 0) ? 1'b1 : h[j];
  endfunction

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run(input logic intl, input int p, input int ncyc);
    logic pulse;
    logic [3:0] ep;
    logic [1:0] ei;
    @(negedge clk);
    rst_n = 0; osc_internal = intl; period = p[PW-1:0]; sync_in = 1; trip = 0;
    enable = 1; chop_on_phase = 0; phase_req = 4'b0101;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    m_latch = 2'b00;
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) begin
        rnd();
        trip = (lfsr[2:1] == 2'b00) ? lfsr[4:3] : 2'b00;
        phase_req = lfsr[8:5];
        chop_on_phase = lfsr[9];
        enable = (lfsr[12:10] != 3'b000);
        if (!intl && lfsr[13]) sync_in = ~sync_in;
      end
      #1;
      if (intl) pulse = ((p == 0 ? 0 : c % p) == 0);
      else pulse = hv(c-3) & ~hv(c-2);
      if (c == 0) chk("R8 reset latches", {6'b0, inh_n}, 8'b0);
      chk(intl ? "R1 sync_out_n" : "R7 sync_out_n idle", {7'b0, sync_out_n},
          {7'b0, intl ? ~pulse : 1'b1});
      if (!enable) begin ep = 4'b0; ei = 2'b0; end
      else if (!chop_on_phase) begin ep = phase_req; ei = m_latch; end
      else begin
        ep = phase_req; ei = 2'b11;
        if (!m_latch[0] && |phase_req[3:2]) ep[3:2] = 2'b11;
        if (!m_latch[1] && |phase_req[1:0]) ep[1:0] = 2'b11;
      end
      chk(!enable ? "R6 phase_out" : chop_on_phase ? "R5 phase_out" : "R4 phase_out",
          {4'b0, phase_out}, {4'b0, ep});
      chk(!enable ? "R6 inh_n" : chop_on_phase ? "R5 inh_n" : "R2/R3/R4 inh_n",
          {6'b0, inh_n}, {6'b0, ei});
      @(posedge clk);
      h[c] = sync_in;
      for (int i = 0; i < 2; i++)
        m_latch[i] = trip[i] ? 1'b0 : (pulse ? 1'b1 : m_latch[i]);
      @(negedge clk);
      #0;
    end
  endtask

  initial begin
    for (int p = 0; p <= 5; p++) run(1'b1, p, 60);
    run(1'b1, 13, 80);
    for (int k = 0; k < 3; k++) run(1'b0, 4, 120);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule